// File: doc/BRIEF.md
# Two-Tier System Reset Controller

This block turns a handful of digital reset causes into two system reset outputs. The harder one, `hard_rst_n`, is driven by loss of supply, by the reset pin when that pin is in reset mode, and by the supply supervisor when its reset enable is set. The softer one, `soft_rst_n`, covers everything the hard reset covers. It also covers a watchdog expiry and a flash key violation, so a hard reset always brings a soft reset with it.

Loss of supply forces both outputs low at once, with no clock edge needed. Every other cause is synchronised first. Every release waits on the clock. After each hard cause goes away, including the return of supply, the hard reset is held for a settle time given as a count of cycles. A single-cycle soft cause is stretched to a fixed minimum width.

The block also drives the address of the vector to fetch when the CPU starts. It keeps a sticky record of which sources fired, which software clears by writing ones.

Top module: `rst_tier_ctrl`

## Requirements
- R1: While `supply_ok` is low, `hard_rst_n` and `soft_rst_n` are both low, and a fall of `supply_ok` drives them low at once, without waiting for a clock edge.
- R2: After `supply_ok` rises, `hard_rst_n` goes high on rising edge number RELEASE_CYCLES+2, counting the first edge after the rise as edge 0.
- R3: A low on `rst_pin_n` while `pin_nmi_sel` is 0 drives `hard_rst_n` low on the third rising edge after it appears. After the pin returns high, release follows the same RELEASE_CYCLES+2 edge timing as in R2.
- R4: While `pin_nmi_sel` is 1, a low on `rst_pin_n` leaves both resets high and leaves the cause register unchanged.
- R5: `svs_low` produces a hard reset only while `svs_rst_en` is 1. With the enable at 0 it has no effect on either reset or on the cause register.
- R6: `soft_rst_n` is low in every cycle in which `hard_rst_n` is low, and both are released on the same edge.
- R7: A one-cycle pulse on `wdt_expire` or `flash_key_err` holds `soft_rst_n` low for exactly SOFT_HOLD+1 cycles and leaves `hard_rst_n` high.
- R8: `fetch_vec` is set as follows:
  - It resets to 16'hFFFE and becomes 16'hFFFE on every hard reset.
  - On a soft-only reset it becomes WDT_VEC for a watchdog cause and FLASH_VEC for a flash cause.
  - A hard cause wins over a soft cause, and the watchdog wins over flash when both arrive in the same cycle.
  - In every other cycle it keeps its value.
- R9: `cause` has bit 0 for the watchdog, bit 1 for a flash key violation, bit 2 for the pin in reset mode, and bit 3 for the enabled supervisor. A bit is set on the third rising edge after its event and stays set until it is cleared.
- R10: A one in `cause_clr` clears the matching cause bit on the next edge. A new event in the same cycle wins over the clear. Loss of supply clears every bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| supply_ok | input | 1 | Supply-good level from the brownout comparator, low means supply lost |
| rst_pin_n | input | 1 | External reset pin level, active low |
| pin_nmi_sel | input | 1 | 1 puts the pin in interrupt mode, where it causes no reset |
| svs_low | input | 1 | Supply supervisor low-voltage flag |
| svs_rst_en | input | 1 | Allows the supervisor flag to cause a hard reset |
| wdt_expire | input | 1 | Watchdog expiry pulse in supervision mode |
| flash_key_err | input | 1 | Flash control key violation pulse |
| cause_clr | input | 4 | Write-one-to-clear strobes for the cause bits |
| hard_rst_n | output | 1 | Hard (power-on) reset, active low |
| soft_rst_n | output | 1 | Soft (power-up clear) reset, active low |
| fetch_vec | output | 16 | Address of the vector the CPU fetches on release |
| cause | output | 4 | Sticky record of reset sources |

## Verification
The bench measures release timing to the exact edge after the supply returns and after the pin returns. A counter that is off by one, or that does not reload when a cause is present, moves the release to the wrong edge.

The bench also drives the pin low in interrupt mode and raises the supervisor flag with its enable off. A design that ignored the mode or the enable would reset there and set a cause bit.

Simultaneous causes check the vector priority: watchdog with flash, flash with pin, and the supervisor flag with the pin in interrupt mode. A wrong priority shows up as the wrong fetch address.

Two more cases target the cause register. A clear lands in the same cycle as a new event, and a design that lets the clear win loses that record. Supply is also dropped between clock edges, and a design that asserts reset only on a clock edge stays high for part of a cycle.

// File: rtl/rst_tier_pkg.sv
package rst_tier_pkg;
  localparam int unsigned VEC_W    = 16;
  localparam int unsigned N_CAUSE  = 4;
  localparam logic [VEC_W-1:0] HARD_VEC = 16'hFFFE;

  typedef enum int unsigned {
    C_WDT   = 0,
    C_FLASH = 1,
    C_PIN   = 2,
    C_SVS   = 3
  } cause_idx_e;
endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/release_timer.sv
module release_timer #(
  parameter int unsigned LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = hold_i || (cnt_q != CW'(LIMIT));
    cnt_d  = hold_i ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == CW'(LIMIT));

  // R2
  hold_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !done_o);
endmodule

// File: rtl/cause_log.sv
module cause_log #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] cause_o
);
  logic [N-1:0] q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_en;
    logic bit_d;
    always_comb begin
      bit_en = set_i[i] | clr_i[i];
      bit_d  = set_i[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (bit_en) q[i] <= bit_d;
    end
  end

  assign cause_o = q;

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_i) == '0) |-> ((cause_o & $past(cause_o)) == $past(cause_o)));
endmodule

// File: rtl/rst_tier_ctrl.sv
module rst_tier_ctrl
  import rst_tier_pkg::*;
#(
  parameter int unsigned      RELEASE_CYCLES = 100000,
  parameter int unsigned      SOFT_HOLD      = 4,
  parameter logic [VEC_W-1:0] WDT_VEC        = 16'hFFFE,
  parameter logic [VEC_W-1:0] FLASH_VEC      = 16'hFFFC
) (
  input  logic               clk,
  input  logic               supply_ok,
  input  logic               rst_pin_n,
  input  logic               pin_nmi_sel,
  input  logic               svs_low,
  input  logic               svs_rst_en,
  input  logic               wdt_expire,
  input  logic               flash_key_err,
  input  logic [N_CAUSE-1:0] cause_clr,
  output logic               hard_rst_n,
  output logic               soft_rst_n,
  output logic [VEC_W-1:0]   fetch_vec,
  output logic [N_CAUSE-1:0] cause
);
  localparam int unsigned SH_W = $clog2(SOFT_HOLD + 2);

  // supply-loss reset, released on the clock
  logic live;
  sync_2ff #(.W(1)) u_live (
    .clk  (clk),
    .rst_n(supply_ok),
    .d_i  (1'b1),
    .q_o  (live)
  );

  logic [5:0] raw_in;
  logic [5:0] syn_in;
  assign raw_in = {rst_pin_n, pin_nmi_sel, svs_low, svs_rst_en, wdt_expire, flash_key_err};

  sync_2ff #(.W(6)) u_in (
    .clk  (clk),
    .rst_n(supply_ok),
    .d_i  (raw_in),
    .q_o  (syn_in)
  );

  logic pin_hit, svs_hit, wdt_hit, fl_hit, hard_req, soft_req;
  logic [N_CAUSE-1:0] set_vec;

  always_comb begin
    pin_hit  = live & ~syn_in[5] & ~syn_in[4];
    svs_hit  = live & syn_in[3] & syn_in[2];
    wdt_hit  = live & syn_in[1];
    fl_hit   = live & syn_in[0];
    hard_req = ~live | pin_hit | svs_hit;
    soft_req = wdt_hit | fl_hit;
    set_vec          = '0;
    set_vec[C_WDT]   = wdt_hit;
    set_vec[C_FLASH] = fl_hit;
    set_vec[C_PIN]   = pin_hit;
    set_vec[C_SVS]   = svs_hit;
  end

  logic rel_done;
  release_timer #(.LIMIT(RELEASE_CYCLES)) u_rel (
    .clk   (clk),
    .rst_n (supply_ok),
    .hold_i(hard_req),
    .done_o(rel_done)
  );

  cause_log #(.N(N_CAUSE)) u_log (
    .clk    (clk),
    .rst_n  (supply_ok),
    .set_i  (set_vec),
    .clr_i  (cause_clr),
    .cause_o(cause)
  );

  logic             hard_q, hard_d;
  logic             soft_q, soft_d;
  logic [SH_W-1:0]  sh_q, sh_d;
  logic [VEC_W-1:0] vec_q, vec_d;

  always_comb begin
    hard_d = rel_done & ~hard_req;
    if (soft_req)          sh_d = SH_W'(SOFT_HOLD);
    else if (sh_q != '0)   sh_d = sh_q - SH_W'(1);
    else                   sh_d = sh_q;
    soft_d = hard_d & ~soft_req & (sh_q == '0);
    vec_d  = vec_q;
    if (hard_req)     vec_d = HARD_VEC;
    else if (wdt_hit) vec_d = WDT_VEC;
    else if (fl_hit)  vec_d = FLASH_VEC;
  end

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok) begin
      hard_q <= 1'b0;
      soft_q <= 1'b0;
      sh_q   <= '0;
      vec_q  <= HARD_VEC;
    end else begin
      hard_q <= hard_d;
      soft_q <= soft_d;
      sh_q   <= sh_d;
      vec_q  <= vec_d;
    end
  end

  assign hard_rst_n = hard_q;
  assign soft_rst_n = soft_q;
  assign fetch_vec  = vec_q;

  // R6
  soft_follows_hard_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    !hard_rst_n |-> !soft_rst_n);

  // R8
  vector_on_hard_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    $fell(hard_rst_n) |-> (fetch_vec == HARD_VEC));
endmodule

// File: tb/rst_tier_ctrl_tb.sv
module rst_tier_ctrl_tb;
  localparam int unsigned REL  = 20;
  localparam int unsigned HOLD = 3;
  localparam logic [15:0] WV   = 16'hFFF0;
  localparam logic [15:0] FV   = 16'hFFF2;

  logic       clk = 1'b0;
  logic       supply_ok, rst_pin_n, pin_nmi_sel, svs_low, svs_rst_en, wdt_expire, flash_key_err;
  logic [3:0] cause_clr;
  logic       hard_rst_n, soft_rst_n;
  logic [15:0] fetch_vec;
  logic [3:0] cause;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rst_tier_ctrl #(
    .RELEASE_CYCLES(REL), .SOFT_HOLD(HOLD), .WDT_VEC(WV), .FLASH_VEC(FV)
  ) u_dut (
    .clk(clk), .supply_ok(supply_ok), .rst_pin_n(rst_pin_n), .pin_nmi_sel(pin_nmi_sel),
    .svs_low(svs_low), .svs_rst_en(svs_rst_en), .wdt_expire(wdt_expire),
    .flash_key_err(flash_key_err), .cause_clr(cause_clr), .hard_rst_n(hard_rst_n),
    .soft_rst_n(soft_rst_n), .fetch_vec(fetch_vec), .cause(cause)
  );

  // stim {nmi_sel, pin_n, svs, svs_en, wdt, flash}, hard_low, soft_low, cause, vec sel
  // vec sel: 0 unchanged, 1 16'hFFFE, 2 watchdog vector, 3 flash vector
  localparam logic [13:0] TBL [10] = '{
    {6'b000000, 1'b1, 1'b1, 4'b0100, 2'd1},
    {6'b100000, 1'b0, 1'b0, 4'b0000, 2'd0},
    {6'b011000, 1'b0, 1'b0, 4'b0000, 2'd0},
    {6'b011100, 1'b1, 1'b1, 4'b1000, 2'd1},
    {6'b010010, 1'b0, 1'b1, 4'b0001, 2'd2},
    {6'b010001, 1'b0, 1'b1, 4'b0010, 2'd3},
    {6'b010011, 1'b0, 1'b1, 4'b0011, 2'd2},
    {6'b000001, 1'b1, 1'b1, 4'b0110, 2'd1},
    {6'b101100, 1'b1, 1'b1, 4'b1000, 2'd1},
    {6'b011010, 1'b0, 1'b1, 4'b0001, 2'd2}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] s);
    {pin_nmi_sel, rst_pin_n, svs_low, svs_rst_en, wdt_expire, flash_key_err} = s;
  endtask

  task automatic idle();
    drive(6'b010000);
  endtask

  task automatic edges_to_release(output int n);
    n = 0;
    while (hard_rst_n !== 1'b1 && n < 1000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic clear_all();
    @(negedge clk);
    cause_clr = 4'hF;
    @(negedge clk);
    cause_clr = 4'h0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int n;
    logic [15:0] last_vec;
    supply_ok = 1'b0;
    cause_clr = 4'h0;
    idle();
    repeat (3) @(negedge clk);
    // R1 R6 R8 R9: reset state
    check("R1 hard in reset", 16'(hard_rst_n), 16'h0);
    check("R6 soft in reset", 16'(soft_rst_n), 16'h0);
    check("R8 vector in reset", fetch_vec, 16'hFFFE);
    check("R9 cause in reset", 16'(cause), 16'h0);

    // R2: release edge after supply return
    supply_ok = 1'b1;
    edges_to_release(n);
    check("R2 release edge count", 16'(n), 16'(REL + 3));
    check("R6 soft released with hard", 16'(soft_rst_n), 16'h1);
    last_vec = 16'hFFFE;

    // table walk: R3 R4 R5 R7 R8 R9
    for (int i = 0; i < 10; i++) begin
      logic [13:0] e;
      logic [15:0] ev;
      e = TBL[i];
      clear_all();
      drive(e[13:8]);
      @(negedge clk);
      idle();
      repeat (2) @(negedge clk);
      check($sformatf("R3/R4/R5 hard entry %0d", i), 16'(hard_rst_n), 16'(!e[7]));
      check($sformatf("R6/R7 soft entry %0d", i), 16'(soft_rst_n), 16'(!e[6]));
      repeat (REL + 10) @(negedge clk);
      check($sformatf("R9 cause entry %0d", i), 16'(cause), 16'(e[5:2]));
      case (e[1:0])
        2'd1:    ev = 16'hFFFE;
        2'd2:    ev = WV;
        2'd3:    ev = FV;
        default: ev = last_vec;
      endcase
      check($sformatf("R8 vector entry %0d", i), fetch_vec, ev);
      last_vec = ev;
    end

    // R3: release after pin held low
    clear_all();
    drive(6'b000000);
    repeat (5) @(negedge clk);
    idle();
    edges_to_release(n);
    check("R3 pin release edge count", 16'(n), 16'(REL + 3));

    // R7: soft pulse width, hard untouched
    begin
      int sl, hl;
      sl = 0; hl = 0;
      @(negedge clk);
      drive(6'b010010);
      @(negedge clk);
      idle();
      for (int k = 0; k < 15; k++) begin
        @(negedge clk);
        if (!soft_rst_n) sl++;
        if (!hard_rst_n) hl++;
      end
      check("R7 soft low cycles", 16'(sl), 16'(HOLD + 1));
      check("R7 hard stays high", 16'(hl), 16'h0);
    end

    // R10: partial clear
    clear_all();
    drive(6'b010011);
    @(negedge clk);
    idle();
    repeat (4) @(negedge clk);
    cause_clr = 4'b0001;
    @(negedge clk);
    cause_clr = 4'h0;
    check("R10 partial clear", 16'(cause), 16'h2);

    // R10: new event wins over clear in the same cycle
    drive(6'b010010);
    @(negedge clk);
    idle();
    @(negedge clk);
    cause_clr = 4'b0001;
    @(negedge clk);
    cause_clr = 4'h0;
    check("R10 set wins over clear", 16'(cause), 16'h3);

    // R1 R10: supply lost between edges
    repeat (6) @(negedge clk);
    #2 supply_ok = 1'b0;
    #2;
    check("R1 hard drops without edge", 16'(hard_rst_n), 16'h0);
    check("R1 soft drops without edge", 16'(soft_rst_n), 16'h0);
    check("R10 supply loss clears cause", 16'(cause), 16'h0);
    @(negedge clk);
    supply_ok = 1'b1;
    edges_to_release(n);
    check("R2 second release edge count", 16'(n), 16'(REL + 3));

    summary();
    $finish;
  end
endmodule